// File: doc/BRIEF.md
# Single-Bit Static RAM with True and Inverted Outputs

This block is a fully decoded static memory of 256 one-bit locations. An 8-bit address selects one cell. A single data input is written into the selected cell on the rising clock edge while the active-low select is asserted and the active-high write input is high. The stored bit is read back combinationally on two outputs. One output carries the bit with the same polarity as the data input. The other carries its inverse.

Each output comes with an output-enable qualifier. This keeps the model synthesizable while it stands in for a three-state driver. When the select input is high, both enables drop so that the outputs can be treated as floating. A deselected device also ignores the write input. Several instances can therefore share one output line, with the select inputs deciding which one drives it. During a write, the outputs follow the data being written rather than the old cell contents.

Memory contents are not initialised by reset. A location reads back a defined value only after it has been written.

Top module: `sbit_sram`

## Requirements
- R1: The memory holds 256 independent one-bit locations selected by the 8-bit `addr_i`. Each location retains the value last written to it.
- R2: While `cs_ni` is 1, both `q_oe_o` and `qn_oe_o` are 0. While `cs_ni` is 0, both are 1.
- R3: When `cs_ni` is 0 and `we_i` is 1 at a rising edge of `clk_i`, `d_i` is stored at the location given by `addr_i` at that edge.
- R4: When `cs_ni` is 1 at a rising edge, no location changes, whatever the values of `we_i` and `d_i`.
- R5: When `cs_ni` is 0 and `we_i` is 0, `q_o` equals the bit stored at `addr_i` and `qn_o` equals its inverse, with no clock edge needed.
- R6: When `cs_ni` is 0 and `we_i` is 1, `q_o` equals `d_i` and `qn_o` equals the inverse of `d_i` in the same cycle.
- R7: `qn_o` is always the bitwise inverse of `q_o`.
- R8: A write changes only the addressed location. The neighbouring addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Write strobe clock; writes take effect on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; does not clear the contents |
| cs_ni | input | 1 | Active-low device select |
| we_i | input | 1 | Active-high write request |
| addr_i | input | 8 | Cell address |
| d_i | input | 1 | Data to store |
| q_o | output | 1 | Stored bit, or the write data during a write |
| q_oe_o | output | 1 | Drive qualifier for q_o |
| qn_o | output | 1 | Inverse of q_o |
| qn_oe_o | output | 1 | Drive qualifier for qn_o |

## Verification
A stuck or wrongly decoded cell shows up only when its own address is read. For that reason every address is written with a position-dependent pattern and then read back. A write that lands on the wrong address shows up as a changed neighbour on the next read. A write that leaks through a deselect shows up as a flipped bit in the read cycle just after the clock edge. Enable and polarity faults on the outputs are visible in the same cycle as the input change that causes them.

// File: rtl/sbit_sram_pkg.sv
package sbit_sram_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } sram_mode_e;
endpackage

// File: rtl/sbit_mode_dec.sv
module sbit_mode_dec
  import sbit_sram_pkg::*;
(
  input  logic       cs_ni,
  input  logic       we_i,
  output sram_mode_e mode_o,
  output logic       wr_en_o
);
  always_comb begin
    if (cs_ni)     mode_o = MODE_OFF;
    else if (we_i) mode_o = MODE_WRITE;
    else           mode_o = MODE_READ;
  end

  assign wr_en_o = (mode_o == MODE_WRITE);
endmodule

// File: rtl/sbit_cell_array.sv
module sbit_cell_array #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d_i,
  output logic              rd_bit_o
);
  logic [DEPTH-1:0] sel;
  logic             cell_q [DEPTH];

  // one-hot row select, gated by the write request
  always_comb begin
    sel = '0;
    if (wr_en_i) sel[addr_i] = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (sel[i]) cell_q[i] <= d_i;
    end
  end

  assign rd_bit_o = cell_q[addr_i];

  p_sel_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  // no write request at an edge with the address held: the read bit stays put
  p_no_write_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && $stable(addr_i)) |=> (rd_bit_o == $past(rd_bit_o) || addr_i != $past(addr_i)));
endmodule

// File: rtl/sbit_out_stage.sv
module sbit_out_stage
  import sbit_sram_pkg::*;
(
  input  sram_mode_e mode_i,
  input  logic       rd_bit_i,
  input  logic       d_i,
  output logic       q_o,
  output logic       q_oe_o,
  output logic       qn_o,
  output logic       qn_oe_o
);
  logic src_bit;

  // during a write the data input is echoed
  assign src_bit = (mode_i == MODE_WRITE) ? d_i : rd_bit_i;
  assign q_o     = src_bit;
  assign qn_o    = ~src_bit;
  assign q_oe_o  = (mode_i != MODE_OFF);
  assign qn_oe_o = (mode_i != MODE_OFF);
endmodule

// File: rtl/sbit_sram.sv
module sbit_sram
  import sbit_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d_i,
  output logic              q_o,
  output logic              q_oe_o,
  output logic              qn_o,
  output logic              qn_oe_o
);
  sram_mode_e mode;
  logic       wr_en;
  logic       rd_bit;

  sbit_mode_dec i_dec (
    .cs_ni   (cs_ni),
    .we_i    (we_i),
    .mode_o  (mode),
    .wr_en_o (wr_en)
  );

  sbit_cell_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .addr_i   (addr_i),
    .d_i      (d_i),
    .rd_bit_o (rd_bit)
  );

  sbit_out_stage i_out (
    .mode_i   (mode),
    .rd_bit_i (rd_bit),
    .d_i      (d_i),
    .q_o      (q_o),
    .q_oe_o   (q_oe_o),
    .qn_o     (qn_o),
    .qn_oe_o  (qn_oe_o)
  );

  p_deselect_float_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!q_oe_o && !qn_oe_o));

  p_select_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |-> (q_oe_o && qn_oe_o));

  p_write_echo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && we_i) |-> (q_o == d_i));

  p_pair_inverse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qn_o == ~q_o);

  // a read right after a write to the same address returns the written bit
  p_read_after_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && we_i) |=> ((!cs_ni && !we_i && addr_i == $past(addr_i)) -> q_o == $past(d_i)));
endmodule

// File: tb/test_sbit_sram.sv
module test_sbit_sram;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic       d_i = 1'b0;
  logic       q_o, q_oe_o, qn_o, qn_oe_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  bit  model [256];

  always #2.5 clk_i = ~clk_i;

  sbit_sram i_sbit_sram (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .we_i(we_i),
    .addr_i(addr_i), .d_i(d_i), .q_o(q_o), .q_oe_o(q_oe_o),
    .qn_o(qn_o), .qn_oe_o(qn_oe_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pat(input int a);
    return (^a[7:0]) ^ a[2];
  endfunction

  // R3 R6: write one location, checking the echo before the edge
  task automatic t_write(input logic [7:0] a, input bit d);
    @(negedge clk_i);
    cs_ni = 1'b0; we_i = 1'b1; addr_i = a; d_i = d;
    #1;
    chk("R6 echo", {q_o, qn_o, q_oe_o, qn_oe_o}, {d, ~d, 2'b11});
    @(negedge clk_i);
    we_i = 1'b0; cs_ni = 1'b1;
    model[a] = d;
  endtask

  // R5 R7: read one location
  task automatic t_read(input string req, input logic [7:0] a);
    @(negedge clk_i);
    cs_ni = 1'b0; we_i = 1'b0; addr_i = a; d_i = ~model[a];
    #1;
    chk(req, {q_o, qn_o, q_oe_o, qn_oe_o}, {model[a], ~model[a], 2'b11});
  endtask

  task automatic t_reset_state();
    #1;
    chk("R2 reset deselected", {q_oe_o, qn_oe_o}, 2'b00);
    chk("R7 reset pair", {1'b0, qn_o ^ q_o}, 2'b01);
  endtask

  // R1: fill all locations with a pattern and read them back
  task automatic t_fill_all();
    for (int a = 0; a < 256; a++) t_write(a[7:0], pat(a));
    for (int a = 0; a < 256; a++) t_read("R1 R5 pattern", a[7:0]);
    for (int a = 0; a < 256; a++) t_write(a[7:0], ~pat(a));
    for (int a = 255; a >= 0; a--) t_read("R1 R5 inverse pattern", a[7:0]);
  endtask

  // R4 R2: deselected write attempt changes nothing, outputs float
  task automatic t_inhibit(input logic [7:0] a);
    @(negedge clk_i);
    cs_ni = 1'b1; we_i = 1'b1; addr_i = a; d_i = ~model[a];
    #1;
    chk("R2 deselect float", {q_oe_o, qn_oe_o}, 2'b00);
    chk("R7 deselect pair", {1'b0, qn_o ^ q_o}, 2'b01);
    @(negedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
    t_read("R4 inhibit kept", a);
  endtask

  // R8: flipping one location leaves its neighbours intact
  task automatic t_neighbours(input logic [7:0] a);
    t_write(a, ~model[a]);
    t_read("R8 target", a);
    t_read("R8 lower", a - 8'd1);
    t_read("R8 upper", a + 8'd1);
    t_read("R8 far", a ^ 8'h80);
  endtask

  // R5 R6: read follows the address without a clock edge
  task automatic t_comb_read();
    @(negedge clk_i);
    cs_ni = 1'b0; we_i = 1'b0;
    addr_i = 8'h10; #0.5;
    chk("R5 comb a", {3'b000, q_o}, {3'b000, model[8'h10]});
    addr_i = 8'h11; #0.5;
    chk("R5 comb b", {3'b000, q_o}, {3'b000, model[8'h11]});
    we_i = 1'b1; d_i = ~model[8'h11]; #0.5;
    chk("R6 echo flip", {q_o, qn_o, 2'b00}, {~model[8'h11], model[8'h11], 2'b00});
    we_i = 1'b0; cs_ni = 1'b1; #0.5;
  endtask

  initial begin
    t_reset_state();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_fill_all();
    t_inhibit(8'h00);
    t_inhibit(8'hA5);
    t_inhibit(8'hFF);
    t_neighbours(8'h55);
    t_neighbours(8'h01);
    t_neighbours(8'hFE);
    t_comb_read();
    t_read("R1 final", 8'h11);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule